// File: doc/BRIEF.md
# Display Timing Control Register Unit

This block is the register file of a display controller. It holds the raster timing parameters, the frame-buffer start address and row pitch, a set of feature enables, the monitor-sense drive, and the vertical-blank interrupt state. Software reaches it through a small request/response bus. Each 32-bit register sits on a 16-byte stride. The bus carries data in little-endian byte order, and the block swaps the bytes on the way in and on the way out.

Turning the display on or off is a deliberate, two-step act. The new on/off choice is written first. It only takes effect once a strobe bit in the same control register has been raised twice. The vertical-blank input sets a status bit. That bit drives the interrupt line when the interrupt is enabled. Software clears it by dropping a dedicated bit in the interrupt-enable register.

The request channel is valid/ready. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. A read produces one response beat. While that beat waits for `rsp_ready`, `req_ready` is held low, so the requester has to keep its request stable until it is taken. Writes produce no response.

Top module: `disp_timing_regs`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high, and the register index is `req_addr[8:4]`. An accepted read raises `rsp_valid` with its data on the next cycle. `rsp_valid` and `rsp_rdata` then hold steady until `rsp_ready` is seen high, and `req_ready` stays low while a response is pending.
- R2: Write data is byte-swapped (bytes 0..3 become 3..0) before it is stored. Read data is the register value byte-swapped the same way.
- R3: Indices 0x01 to 0x10 are timing parameters that keep the low 12 bits of the written value. Index 0x08 keeps only 10 bits and index 0x0E keeps only 8 bits.
- R4: Index 0x13 (frame-buffer base) keeps the written value ANDed with 0x3FFFE0, and index 0x14 (row pitch) keeps it ANDed with 0x7FE0. Both are also driven on `fb_base_o` and `row_pitch_o`.
- R5: The control register at index 0x12 keeps 11 bits; bit 3 is the strobe and bit 10 is the off flag. A write that flips bit 10 stores the value and zeroes the strobe count. Otherwise, a write that flips bit 3 stores the value and, if bit 3 goes 0 to 1, increments the count. When the count reaches 2, `disp_enabled` becomes the inverse of bit 10. Any other write only stores the value.
- R6: A write to index 0x15 sets `sense_dir` to the inverse of value bits [5:3], and `sense_lvl` to (bits [2:0] AND `sense_dir`) OR NOT `sense_dir`. A read of index 0x15 returns `sense_id_in` in bits [8:6], with all other bits zero.
- R7: Index 0x16 keeps 12 bits. Bit 11 set removes blanking (`blank_out` low), and bit 11 clear forces `blank_out` high. Index 0x17 keeps 2 bits.
- R8: Bit 2 of index 0x1A is the vertical-blank status. On the cycle after `vblank_in` changes, it takes the new input level. `irq_out` is that status ANDed with bit 2 of index 0x19.
- R9: Index 0x19 keeps 4 bits. A write that takes its bit 3 from 1 to 0 clears the vertical-blank status, unless `vblank_in` changes in the same cycle.
- R10: Index 0x00, index 0x11 and index 0x18 all read as 0. A non-zero write to index 0x11 sets the sticky flag `cnt_test_warn`.
- R11: Indices 0x1B to 0x1F read 0 and ignore writes, and index 0x1A ignores writes. A read with `req_addr[3:0]` non-zero still returns the register at its index, and it sets the sticky flag `unaligned_err`.
- R12: After reset all registers are 0, so `disp_enabled`, `irq_out` and both flags are 0. `blank_out` is 1, `sense_dir` is 3'b111, `sense_lvl` is 3'b000, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset; bits [8:4] select the register |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_rdata | output | 32 | Read data, little-endian |
| vblank_in | input | 1 | Vertical-blank level, synchronous to clk |
| irq_out | output | 1 | Vertical-blank interrupt |
| disp_enabled | output | 1 | Display armed |
| blank_out | output | 1 | Force blanking |
| fb_base_o | output | 22 | Frame-buffer base address |
| row_pitch_o | output | 15 | Row pitch in bytes |
| sense_dir | output | 3 | Monitor-sense drive enables |
| sense_lvl | output | 3 | Monitor-sense drive levels |
| sense_id_in | input | 3 | Sensed monitor code |
| cnt_test_warn | output | 1 | Sticky: non-zero counter-test write seen |
| unaligned_err | output | 1 | Sticky: unaligned read seen |

## Verification
The assertions assume that `vblank_in` is already synchronous to `clk`. They also assume that a requester holds a request unchanged while `req_ready` is low. The bench changes every input only at falling edges and issues one request at a time. It never makes `vblank_in` change in the same cycle as an interrupt-clear write, so the status-clear ordering is always unambiguous. The bench stalls the response by holding `rsp_ready` low only in the dedicated back-pressure scenario, and it issues no new request during that stall.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  localparam logic [IDX_W-1:0] IX_LINE   = 5'h00;
  localparam logic [IDX_W-1:0] IX_CNTTST = 5'h11;
  localparam logic [IDX_W-1:0] IX_CTL    = 5'h12;
  localparam logic [IDX_W-1:0] IX_BASE   = 5'h13;
  localparam logic [IDX_W-1:0] IX_PITCH  = 5'h14;
  localparam logic [IDX_W-1:0] IX_SENSE  = 5'h15;
  localparam logic [IDX_W-1:0] IX_ENAB   = 5'h16;
  localparam logic [IDX_W-1:0] IX_DIV    = 5'h17;
  localparam logic [IDX_W-1:0] IX_REFR   = 5'h18;
  localparam logic [IDX_W-1:0] IX_INTEN  = 5'h19;
  localparam logic [IDX_W-1:0] IX_INTST  = 5'h1A;

  function automatic logic [DATA_W-1:0] swap32(input logic [DATA_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/dtr_timing_bank.sv
module dtr_timing_bank #(
  parameter int FIRST   = 1,
  parameter int N       = 16,
  parameter int W       = 12,
  parameter int NARROW1 = 8,
  parameter int W1      = 10,
  parameter int NARROW2 = 14,
  parameter int W2      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [W-1:0] wr_val,
  input  logic [4:0]  rd_idx,
  output logic        rd_hit,
  output logic [W-1:0] rd_val
);
  localparam int AW = $clog2(N);

  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam int IDX = FIRST + g;
    localparam int KW  = (IDX == NARROW1) ? W1 : (IDX == NARROW2) ? W2 : W;
    localparam logic [W-1:0] MASK = W'((64'd1 << KW) - 64'd1);
    always_ff @(posedge clk) begin
      if (!rst_n) slot[g] <= '0;
      else if (wr_en && wr_idx == 5'(IDX)) slot[g] <= wr_val & MASK;
    end
  end

  logic [4:0] off;
  always_comb begin
    off    = rd_idx - 5'(FIRST);
    rd_hit = (rd_idx >= 5'(FIRST)) && (rd_idx < 5'(FIRST + N));
    rd_val = rd_hit ? slot[off[AW-1:0]] : '0;
  end
endmodule

// File: rtl/dtr_arm_ctrl.sv
module dtr_arm_ctrl #(
  parameter int CW_BITS   = 11,
  parameter int STB_BIT   = 3,
  parameter int OFF_BIT   = 10,
  parameter int ARM_COUNT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CW_BITS-1:0] wr_val,
  output logic [CW_BITS-1:0] ctl,
  output logic               disp_en
);
  localparam int NW = $clog2(ARM_COUNT + 1);

  logic [NW-1:0] cnt;
  logic [NW-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      cnt     <= '0;
      disp_en <= 1'b0;
    end else if (wr_en) begin
      ctl <= wr_val;
      if (ctl[OFF_BIT] != wr_val[OFF_BIT]) begin
        cnt <= '0;
      end else if (ctl[STB_BIT] != wr_val[STB_BIT] && wr_val[STB_BIT]) begin
        if (cnt < NW'(ARM_COUNT)) cnt <= cnt_inc;
        if (cnt_inc >= NW'(ARM_COUNT)) disp_en <= !wr_val[OFF_BIT];
      end
    end
  end
endmodule

// File: rtl/dtr_vbl_irq.sv
module dtr_vbl_irq #(
  parameter int EW      = 4,
  parameter int EN_BIT  = 2,
  parameter int CLR_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vblank_in,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_val,
  output logic [EW-1:0] inten,
  output logic          vbl_stat,
  output logic          irq_out
);
  logic vb_q;
  logic clr;

  assign clr = wr_en && inten[CLR_BIT] && !wr_val[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb_q     <= 1'b0;
      vbl_stat <= 1'b0;
      inten    <= '0;
    end else begin
      vb_q <= vblank_in;
      if (vblank_in != vb_q) vbl_stat <= vblank_in;
      else if (clr)          vbl_stat <= 1'b0;
      if (wr_en) inten <= wr_val;
    end
  end

  assign irq_out = vbl_stat && inten[EN_BIT];
endmodule

// File: rtl/disp_timing_regs.sv
module disp_timing_regs
  import dtr_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int TIM_W   = 12,
  parameter int TIM_N   = 16,
  parameter int BASE_W  = 22,
  parameter int PITCH_W = 15,
  parameter int ENAB_W  = 12,
  parameter int CTL_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  input  logic               vblank_in,
  output logic               irq_out,
  output logic               disp_enabled,
  output logic               blank_out,
  output logic [BASE_W-1:0]  fb_base_o,
  output logic [PITCH_W-1:0] row_pitch_o,
  output logic [2:0]         sense_dir,
  output logic [2:0]         sense_lvl,
  input  logic [2:0]         sense_id_in,
  output logic               cnt_test_warn,
  output logic               unaligned_err
);
  localparam logic [BASE_W-1:0]  BASE_MASK  = BASE_W'(22'h3FFFE0);
  localparam logic [PITCH_W-1:0] PITCH_MASK = PITCH_W'(15'h7FE0);
  localparam int BLANK_OFF_BIT = 11;

  logic [IDX_W-1:0] idx;
  logic             wr_fire, rd_fire;
  logic [31:0]      wval;

  assign idx       = req_addr[ADDR_W-1:4];
  assign req_ready = !rsp_valid;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;
  assign wval      = swap32(req_wdata);

  logic             tim_hit;
  logic [TIM_W-1:0] tim_rd;

  dtr_timing_bank #(.FIRST(1), .N(TIM_N), .W(TIM_W)) u_tim (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_idx(idx),
    .wr_val(wval[TIM_W-1:0]), .rd_idx(idx), .rd_hit(tim_hit), .rd_val(tim_rd)
  );

  logic [CTL_W-1:0] ctl;
  dtr_arm_ctrl #(.CW_BITS(CTL_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire && idx == IX_CTL),
    .wr_val(wval[CTL_W-1:0]), .ctl(ctl), .disp_en(disp_enabled)
  );

  logic [3:0] inten;
  logic       vbl_stat;
  dtr_vbl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .vblank_in(vblank_in),
    .wr_en(wr_fire && idx == IX_INTEN), .wr_val(wval[3:0]),
    .inten(inten), .vbl_stat(vbl_stat), .irq_out(irq_out)
  );

  logic [BASE_W-1:0]  fb_base;
  logic [PITCH_W-1:0] pitch;
  logic [5:0]         sense_raw;
  logic [ENAB_W-1:0]  enab;
  logic [1:0]         div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_base       <= '0;
      pitch         <= '0;
      sense_raw     <= '0;
      enab          <= '0;
      div           <= '0;
      cnt_test_warn <= 1'b0;
    end else if (wr_fire) begin
      case (idx)
        IX_BASE:   fb_base   <= wval[BASE_W-1:0] & BASE_MASK;
        IX_PITCH:  pitch     <= wval[PITCH_W-1:0] & PITCH_MASK;
        IX_SENSE:  sense_raw <= wval[5:0];
        IX_ENAB:   enab      <= wval[ENAB_W-1:0];
        IX_DIV:    div       <= wval[1:0];
        IX_CNTTST: if (wval != '0) cnt_test_warn <= 1'b1;
        default: ;
      endcase
    end
  end

  assign fb_base_o   = fb_base;
  assign row_pitch_o = pitch;
  assign blank_out   = !enab[BLANK_OFF_BIT];
  assign sense_dir   = ~sense_raw[5:3];
  assign sense_lvl   = (sense_raw[2:0] & sense_dir) | ~sense_dir;

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (tim_hit) begin
      rd_val = 32'(tim_rd);
    end else begin
      case (idx)
        IX_CTL:   rd_val = 32'(ctl);
        IX_BASE:  rd_val = 32'(fb_base);
        IX_PITCH: rd_val = 32'(pitch);
        IX_SENSE: rd_val = 32'({sense_id_in, 6'b0});
        IX_ENAB:  rd_val = 32'(enab);
        IX_DIV:   rd_val = 32'(div);
        IX_INTEN: rd_val = 32'(inten);
        IX_INTST: rd_val = 32'({vbl_stat, 2'b00});
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      unaligned_err <= 1'b0;
    end else begin
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= swap32(rd_val);
        if (req_addr[3:0] != 4'd0) unaligned_err <= 1'b1;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/disp_timing_regs_chk.sv
module disp_timing_regs_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              vblank_in,
  input logic              irq_out,
  input logic              disp_enabled,
  input logic              unaligned_err,
  input logic [3:0]        inten_q
);
  logic wr_fire, rd_fire;
  logic [4:0] idx;
  assign wr_fire = req_valid && req_ready && req_write;
  assign rd_fire = req_valid && req_ready && !req_write;
  assign idx     = req_addr[ADDR_W-1:4];

  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r5_arm_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_enabled) |-> $past(wr_fire && idx == 5'h12));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> inten_q[2]);

  a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(vblank_in) || $past(wr_fire && idx == 5'h19));

  a_r9_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> $past(!vblank_in) || $past(wr_fire && idx == 5'h19));

  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unaligned_err) |-> $past(rd_fire && req_addr[3:0] != 4'd0));
endmodule

bind disp_timing_regs disp_timing_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .vblank_in(vblank_in),
  .irq_out(irq_out), .disp_enabled(disp_enabled),
  .unaligned_err(unaligned_err), .inten_q(inten)
);

// File: tb/tb_disp_timing_regs.sv
module tb_disp_timing_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        vblank_in = 1'b0;
  logic [2:0]  sense_id_in = 3'd0;
  logic        req_ready, rsp_valid, irq_out, disp_enabled, blank_out;
  logic [31:0] rsp_rdata;
  logic [21:0] fb_base_o;
  logic [14:0] row_pitch_o;
  logic [2:0]  sense_dir, sense_lvl;
  logic        cnt_test_warn, unaligned_err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_timing_regs dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .vblank_in(vblank_in), .irq_out(irq_out), .disp_enabled(disp_enabled),
    .blank_out(blank_out), .fb_base_o(fb_base_o), .row_pitch_o(row_pitch_o),
    .sense_dir(sense_dir), .sense_lvl(sense_lvl), .sense_id_in(sense_id_in),
    .cnt_test_warn(cnt_test_warn), .unaligned_err(unaligned_err)
  );

  function automatic logic [31:0] le(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = le(v);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_raw(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    logic [31:0] d;
    rd_raw(a, d);
    v = le(d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R12 disp_enabled", 32'(disp_enabled), 0);
    chk("R12 blank_out", 32'(blank_out), 1);
    chk("R12 irq_out", 32'(irq_out), 0);
    chk("R12 req_ready", 32'(req_ready), 1);
    chk("R12 sense_dir", 32'(sense_dir), 7);
    chk("R12 sense_lvl", 32'(sense_lvl), 0);
    chk("R12 flags", 32'({cnt_test_warn, unaligned_err}), 0);
    rd(9'h130, v);
    chk("R12 base reads 0", v, 0);
  endtask

  task automatic t_byte_order;
    logic [31:0] d;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h010; req_wdata = 32'h34120000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd_raw(9'h010, d);
    chk("R2 swapped round trip", d, 32'h34020000);
  endtask

  task automatic t_timing;
    logic [31:0] v;
    wr(9'h010, 32'hFFFFFFFF); rd(9'h010, v); chk("R3 idx01 12b", v, 32'hFFF);
    wr(9'h080, 32'hFFFFFFFF); rd(9'h080, v); chk("R3 idx08 10b", v, 32'h3FF);
    wr(9'h0E0, 32'hFFFFFFFF); rd(9'h0E0, v); chk("R3 idx0E 8b", v, 32'hFF);
    wr(9'h100, 32'hFFFFFFFF); rd(9'h100, v); chk("R3 idx10 12b", v, 32'hFFF);
    wr(9'h0A0, 32'h00000ABC); rd(9'h0A0, v); chk("R3 idx0A value", v, 32'hABC);
    rd(9'h0E0, v); chk("R3 idx0E kept", v, 32'hFF);
  endtask

  task automatic t_base_pitch;
    logic [31:0] v;
    wr(9'h130, 32'hFFFFFFFF); rd(9'h130, v);
    chk("R4 base mask", v, 32'h3FFFE0);
    chk("R4 base pin", 32'(fb_base_o), 32'h3FFFE0);
    wr(9'h140, 32'hFFFFFFFF); rd(9'h140, v);
    chk("R4 pitch mask", v, 32'h7FE0);
    chk("R4 pitch pin", 32'(row_pitch_o), 32'h7FE0);
  endtask

  task automatic t_arm;
    wr(9'h120, 32'h400); chk("R5 off flip no arm", 32'(disp_enabled), 0);
    wr(9'h120, 32'h000);
    wr(9'h120, 32'h008); chk("R5 one strobe", 32'(disp_enabled), 0);
    wr(9'h120, 32'h000); chk("R5 strobe fall", 32'(disp_enabled), 0);
    wr(9'h120, 32'h008); chk("R5 second strobe enables", 32'(disp_enabled), 1);
    wr(9'h120, 32'h408); chk("R5 off flip keeps state", 32'(disp_enabled), 1);
    wr(9'h120, 32'h400);
    wr(9'h120, 32'h408); chk("R5 recount one", 32'(disp_enabled), 1);
    wr(9'h120, 32'h400);
    wr(9'h120, 32'h408); chk("R5 second strobe disables", 32'(disp_enabled), 0);
  endtask

  task automatic t_sense;
    logic [31:0] v;
    wr(9'h150, 32'h17);
    chk("R6 dir a", 32'(sense_dir), 32'h5);
    chk("R6 lvl a", 32'(sense_lvl), 32'h7);
    wr(9'h150, 32'h30);
    chk("R6 dir b", 32'(sense_dir), 32'h1);
    chk("R6 lvl b", 32'(sense_lvl), 32'h6);
    sense_id_in = 3'd5;
    rd(9'h150, v);
    chk("R6 sense read", v, 32'h140);
  endtask

  task automatic t_enables;
    logic [31:0] v;
    wr(9'h160, 32'h800); chk("R7 blank off", 32'(blank_out), 0);
    wr(9'h160, 32'hFFFF); rd(9'h160, v); chk("R7 enab 12b", v, 32'hFFF);
    wr(9'h160, 32'h0); chk("R7 blank forced", 32'(blank_out), 1);
    wr(9'h170, 32'h7); rd(9'h170, v); chk("R7 div 2b", v, 32'h3);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(9'h190, 32'hFF); rd(9'h190, v); chk("R9 inten 4b", v, 32'hF);
    wr(9'h190, 32'h4); chk("R9 clear idle", 32'(irq_out), 0);
    @(negedge clk); vblank_in = 1'b1;
    @(negedge clk); chk("R8 irq follows vblank", 32'(irq_out), 1);
    rd(9'h1A0, v); chk("R8 status bit2", v, 32'h4);
    wr(9'h190, 32'hC);
    wr(9'h190, 32'h4); chk("R9 clear on 1to0", 32'(irq_out), 0);
    rd(9'h1A0, v); chk("R9 status cleared", v, 0);
    @(negedge clk); vblank_in = 1'b0;
    @(negedge clk); vblank_in = 1'b1;
    @(negedge clk); chk("R8 re-raise", 32'(irq_out), 1);
    wr(9'h190, 32'h0); chk("R8 gated off", 32'(irq_out), 0);
    rd(9'h1A0, v); chk("R8 status kept", v, 32'h4);
    @(negedge clk); vblank_in = 1'b0;
    @(negedge clk); rd(9'h1A0, v); chk("R8 status drops", v, 0);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    rd(9'h000, v); chk("R10 line reads 0", v, 0);
    wr(9'h110, 32'h0); chk("R10 zero no warn", 32'(cnt_test_warn), 0);
    wr(9'h110, 32'h5); chk("R10 warn set", 32'(cnt_test_warn), 1);
    rd(9'h110, v); chk("R10 cnttst reads 0", v, 0);
    wr(9'h180, 32'h3FF); rd(9'h180, v); chk("R10 refresh reads 0", v, 0);
  endtask

  task automatic t_unknown;
    logic [31:0] v;
    wr(9'h1C0, 32'hFFFFFFFF); rd(9'h1C0, v); chk("R11 unknown reads 0", v, 0);
    wr(9'h1A0, 32'hFFFFFFFF); rd(9'h1A0, v); chk("R11 status ro", v, 0);
    chk("R11 no err yet", 32'(unaligned_err), 0);
    rd(9'h134, v); chk("R11 unaligned data", v, 32'h3FFFE0);
    chk("R11 err set", 32'(unaligned_err), 1);
  endtask

  task automatic t_backpressure;
    logic [31:0] d0;
    wr(9'h020, 32'h123);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 9'h020;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 rsp valid", 32'(rsp_valid), 1);
    chk("R1 ready low", 32'(req_ready), 0);
    d0 = rsp_rdata;
    repeat (3) @(negedge clk);
    chk("R1 rsp held", 32'(rsp_valid), 1);
    chk("R1 data stable", rsp_rdata, d0);
    chk("R1 data value", le(rsp_rdata), 32'h123);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R1 rsp drained", 32'(rsp_valid), 0);
    chk("R1 ready back", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_order();
    t_timing();
    t_base_pitch();
    t_arm();
    t_sense();
    t_enables();
    t_irq();
    t_misc();
    t_unknown();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule